// File: doc/BRIEF.md
# NAND ECC Engine Control and Status Registers

This block is the register bank that sits in front of a chunk-based NAND error-correction datapath. Software reaches it over a simple 32-bit register bus made of an address, a write enable, write data and read data. Reads are combinational and writes take effect on the clock edge. The bank holds the engine enable and the correction-type index, the transfer and layout mode, the geometry words, and the system DMA addresses and control. It also reports a read-only breakdown of each spare chunk that depends on the selected correction type, and a version word.

Datapath event inputs raise interrupt status bits in two stages. A status-enable mask decides whether an event is recorded at all. A separate signal-enable mask decides whether a recorded bit drives the single interrupt line. Writing to the DMA control word with its start bit set sends a one-cycle start strobe to the datapath, together with the stored transfer direction.

No data streams through this block, so every pin is a plain control or status signal with no handshake.

Top module: `ecc_csr_top`

## Requirements
- R1: After reset, every writable register reads zero, `irq`, `dma_start`, `cfg_en` and `dma_read` are low, and `cfg_type` is zero.
- R2: Word 0x00 keeps the engine enable in bit 0 and the 4-bit correction-type index in bits 6:3. All other bits read zero. `cfg_en` and `cfg_type` reflect the stored values.
- R3: Word 0x10 keeps only bits 0 (increasing burst), 2 (interleaved layout), 4 (memory-to-memory) and 5 (mapping). Other bits read zero.
- R4: Words 0x14, 0x20, 0x24, 0x30, 0x44 and 0x48 each store and return all 32 written bits.
- R5: Status word 0x04 has bit 0 transfer done, bit 1 main DMA, bit 2 spare DMA, bit 3 ECC error, bit 4 spare timeout and bit 5 main timeout. An event pulse on `evt_in[i]` sets status bit i at the next edge only if bit i of mask word 0x08 is set.
- R6: Writing ones to 0x04 clears those status bits. An enabled event in the same cycle as a clear leaves its bit set. Writes of zero bits leave status unchanged.
- R7: `irq` is high exactly when some status bit is set whose bit in mask word 0x0C is also set.
- R8: A write to 0x40 stores bit 1 (read from NAND when set), bit 29 and bit 30. `dma_read` follows bit 1. If bit 31 is written as one, `dma_start` is high for exactly the one cycle after that edge. Bit 31 always reads zero.
- R9: Word 0x28 is read-only and encodes the spare chunk as: meta in bits 7:0, parity in 15:8, reserved in 23:16, total in 31:24. Meta is 8. Correction type k selects strength 4, 8, 40 or 48 for k = 0, 1, 2, 3, and any k above 3 is treated as 3. Parity is ceil(14*strength/8). Total is 32 for k of 0 or 1 and 96 otherwise. Reserved is total minus meta minus parity.
- R10: Word 0xD0 is read-only and returns the version number (default 3) in bits 31:16, with zeros below.
- R11: Any address not listed above reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte address of the register word |
| reg_we | input | 1 | Write enable for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_in | input | 6 | One-cycle event pulses from the datapath, one per status bit |
| cfg_en | output | 1 | Engine enable |
| cfg_type | output | 4 | Correction-type index |
| dma_start | output | 1 | One-cycle transfer start strobe |
| dma_read | output | 1 | Transfer direction, high for read from NAND |
| irq | output | 1 | Interrupt request |

## Verification
A status bit that latched without being enabled, or that survived a clear, shows up on `irq` and on a read of 0x04 in the very next cycle. The bench compares both against a model of the two masks after every event burst. A bad start decode shows as a missing, stretched or spurious strobe one cycle after the write. A wrong spare-size lookup shows at once on a read of 0x28, whose four fields are checked against each other and against the strength table for every type index. Random writes to the geometry words and to unmapped addresses bring out lost or aliased storage on the next read-back.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
  localparam logic [7:0] A_CFG   = 8'h00;
  localparam logic [7:0] A_STS   = 8'h04;
  localparam logic [7:0] A_SEN   = 8'h08;
  localparam logic [7:0] A_SIG   = 8'h0C;
  localparam logic [7:0] A_MODE  = 8'h10;
  localparam logic [7:0] A_SLV   = 8'h14;
  localparam logic [7:0] A_CHSZ  = 8'h20;
  localparam logic [7:0] A_MSZ   = 8'h24;
  localparam logic [7:0] A_SPARE = 8'h28;
  localparam logic [7:0] A_CCNT  = 8'h30;
  localparam logic [7:0] A_DCTL  = 8'h40;
  localparam logic [7:0] A_DMAIN = 8'h44;
  localparam logic [7:0] A_DSPR  = 8'h48;
  localparam logic [7:0] A_VER   = 8'hD0;

  localparam int N_WORD = 6;
  localparam logic [5:0] MODE_MASK = 6'b110101;

  typedef struct packed {
    logic [7:0] total;
    logic [7:0] rsv;
    logic [7:0] parity;
    logic [7:0] meta;
  } spare_t;

  function automatic logic [7:0] word_addr(input int i);
    case (i)
      0: word_addr = A_SLV;
      1: word_addr = A_CHSZ;
      2: word_addr = A_MSZ;
      3: word_addr = A_CCNT;
      4: word_addr = A_DMAIN;
      default: word_addr = A_DSPR;
    endcase
  endfunction
endpackage

// File: rtl/ecc_csr_spare.sv
module ecc_csr_spare #(
  parameter int META_B = 8,
  parameter int PBITS_PER_T = 14,
  parameter int SPARE_SMALL = 32,
  parameter int SPARE_LARGE = 96
) (
  input  logic [3:0]            type_idx,
  output ecc_csr_pkg::spare_t   fields
);
  logic [1:0] sel;
  int strength;
  int par_b;
  int tot_b;

  always_comb begin
    sel = (type_idx > 4'd3) ? 2'd3 : type_idx[1:0];
    case (sel)
      2'd0: strength = 4;
      2'd1: strength = 8;
      2'd2: strength = 40;
      default: strength = 48;
    endcase
    par_b = (PBITS_PER_T * strength + 7) / 8;
    tot_b = sel[1] ? SPARE_LARGE : SPARE_SMALL;
    fields.meta   = 8'(META_B);
    fields.parity = 8'(par_b);
    fields.total  = 8'(tot_b);
    fields.rsv    = 8'(tot_b - META_B - par_b);
  end
endmodule

// File: rtl/ecc_csr_irq.sv
module ecc_csr_irq #(
  parameter int N_EVT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] sts_en,
  input  logic [N_EVT-1:0] sig_en,
  input  logic             clr_we,
  input  logic [N_EVT-1:0] clr_mask,
  output logic [N_EVT-1:0] sts,
  output logic             irq
);
  genvar g;
  generate
    for (g = 0; g < N_EVT; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sts[g] <= 1'b0;
        else if (evt[g] && sts_en[g])
          sts[g] <= 1'b1;
        else if (clr_we && clr_mask[g])
          sts[g] <= 1'b0;
      end
    end
  endgenerate

  assign irq = |(sts & sig_en);
endmodule

// File: rtl/ecc_csr_wordbank.sv
module ecc_csr_wordbank #(
  parameter int ADDR_W = 8,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 hit
);
  import ecc_csr_pkg::*;
  logic [DW-1:0]     word_q [N_WORD];
  logic [N_WORD-1:0] sel;

  genvar g;
  generate
    for (g = 0; g < N_WORD; g++) begin : g_word
      assign sel[g] = (addr == ADDR_W'(word_addr(g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          word_q[g] <= '0;
        else if (we && sel[g])
          word_q[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_WORD; i++)
      if (sel[i]) rdata = word_q[i];
  end
  assign hit = |sel;
endmodule

// File: rtl/ecc_csr_top.sv
module ecc_csr_top
  import ecc_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_EVT = 6,
  parameter logic [15:0] VERSION = 16'h0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              cfg_en,
  output logic [3:0]        cfg_type,
  output logic              dma_start,
  output logic              dma_read,
  output logic              irq
);
  localparam int DCTL_START = 31;
  localparam int DCTL_CSYS  = 30;
  localparam int DCTL_CNAND = 29;
  localparam int DCTL_DIR   = 1;

  logic wr_cfg, wr_sts, wr_sen, wr_sig, wr_mode, wr_dctl;
  assign wr_cfg  = reg_we && (reg_addr == ADDR_W'(A_CFG));
  assign wr_sts  = reg_we && (reg_addr == ADDR_W'(A_STS));
  assign wr_sen  = reg_we && (reg_addr == ADDR_W'(A_SEN));
  assign wr_sig  = reg_we && (reg_addr == ADDR_W'(A_SIG));
  assign wr_mode = reg_we && (reg_addr == ADDR_W'(A_MODE));
  assign wr_dctl = reg_we && (reg_addr == ADDR_W'(A_DCTL));

  logic             en_q;
  logic [3:0]       type_q;
  logic [5:0]       mode_q;
  logic [N_EVT-1:0] sts_en_q;
  logic [N_EVT-1:0] sig_en_q;
  logic             dir_q, cnand_q, csys_q, start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      type_q   <= '0;
      mode_q   <= '0;
      sts_en_q <= '0;
      sig_en_q <= '0;
      dir_q    <= 1'b0;
      cnand_q  <= 1'b0;
      csys_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        en_q   <= reg_wdata[0];
        type_q <= reg_wdata[6:3];
      end
      if (wr_mode) mode_q   <= reg_wdata[5:0] & MODE_MASK;
      if (wr_sen)  sts_en_q <= reg_wdata[N_EVT-1:0];
      if (wr_sig)  sig_en_q <= reg_wdata[N_EVT-1:0];
      if (wr_dctl) begin
        dir_q   <= reg_wdata[DCTL_DIR];
        cnand_q <= reg_wdata[DCTL_CNAND];
        csys_q  <= reg_wdata[DCTL_CSYS];
      end
      start_q <= wr_dctl && reg_wdata[DCTL_START];
    end
  end

  logic [N_EVT-1:0] irq_sts;
  ecc_csr_irq #(.N_EVT(N_EVT)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .sts_en(sts_en_q),
    .sig_en(sig_en_q), .clr_we(wr_sts), .clr_mask(reg_wdata[N_EVT-1:0]),
    .sts(irq_sts), .irq(irq)
  );

  spare_t spare_f;
  ecc_csr_spare u_spare (.type_idx(type_q), .fields(spare_f));

  logic [31:0] bank_rdata;
  logic        bank_hit;
  ecc_csr_wordbank #(.ADDR_W(ADDR_W), .DW(32)) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .rdata(bank_rdata), .hit(bank_hit)
  );

  always_comb begin
    reg_rdata = '0;
    if (bank_hit)
      reg_rdata = bank_rdata;
    else if (reg_addr == ADDR_W'(A_CFG))
      reg_rdata = {25'b0, type_q, 2'b0, en_q};
    else if (reg_addr == ADDR_W'(A_STS))
      reg_rdata = 32'(irq_sts);
    else if (reg_addr == ADDR_W'(A_SEN))
      reg_rdata = 32'(sts_en_q);
    else if (reg_addr == ADDR_W'(A_SIG))
      reg_rdata = 32'(sig_en_q);
    else if (reg_addr == ADDR_W'(A_MODE))
      reg_rdata = {26'b0, mode_q};
    else if (reg_addr == ADDR_W'(A_SPARE))
      reg_rdata = spare_f;
    else if (reg_addr == ADDR_W'(A_DCTL))
      reg_rdata = {1'b0, csys_q, cnand_q, 27'b0, dir_q, 1'b0};
    else if (reg_addr == ADDR_W'(A_VER))
      reg_rdata = {VERSION, 16'h0000};
  end

  assign cfg_en    = en_q;
  assign cfg_type  = type_q;
  assign dma_start = start_q;
  assign dma_read  = dir_q;
endmodule

// File: rtl/ecc_csr_chk.sv
module ecc_csr_chk #(
  parameter int ADDR_W = 8,
  parameter int N_EVT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [N_EVT-1:0]  evt_in,
  input logic [N_EVT-1:0]  sts,
  input logic [N_EVT-1:0]  sts_en,
  input logic [N_EVT-1:0]  sig_en,
  input logic              dma_start,
  input logic              irq
);
  // R5
  sts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts)) & ~$past(evt_in & sts_en)) == '0);

  // R6
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && $past(reg_addr) == ADDR_W'(8'h04)) |->
    ((sts & $past(reg_wdata[N_EVT-1:0]) & ~$past(evt_in & sts_en)) == '0));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en == '0) |-> !irq);

  // R8
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  // R8
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(reg_we && reg_addr == ADDR_W'(8'h40) && reg_wdata[31]));

  // R9
  spare_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8'h28)) |->
    (8'(reg_rdata[7:0] + reg_rdata[15:8] + reg_rdata[23:16]) == reg_rdata[31:24]));
endmodule

bind ecc_csr_top ecc_csr_chk #(.ADDR_W(ADDR_W), .N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
  .sts(irq_sts), .sts_en(sts_en_q), .sig_en(sig_en_q),
  .dma_start(dma_start), .irq(irq)
);

// File: tb/ecc_csr_top_test.sv
module ecc_csr_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_in = '0;
  logic        cfg_en, dma_start, dma_read, irq;
  logic [3:0]  cfg_type;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_csr_top uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .cfg_en(cfg_en), .cfg_type(cfg_type), .dma_start(dma_start),
    .dma_read(dma_read), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  function automatic logic [31:0] spare_exp(input logic [3:0] k);
    int t, par, tot;
    int s = (k > 3) ? 3 : int'(k);
    t = (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 40 : 48;
    par = (14 * t + 7) / 8;
    tot = (s < 2) ? 32 : 96;
    return {8'(tot), 8'(tot - 8 - par), 8'(par), 8'd8};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] words [6];
    logic [7:0]  waddr [6];
    logic [5:0]  m_sts, m_en, m_sig;
    int unused_seed;
    unused_seed = $urandom(32'd7321);
    waddr[0] = 8'h14; waddr[1] = 8'h20; waddr[2] = 8'h24;
    waddr[3] = 8'h30; waddr[4] = 8'h44; waddr[5] = 8'h48;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk({28'b0, irq, dma_start, cfg_en, dma_read}, 32'h0, "R1 outputs");
    chk({28'b0, cfg_type}, 32'h0, "R1 cfg_type");
    rd(8'h00, 32'h0, "R1 cfg");
    rd(8'h04, 32'h0, "R1 sts");
    rd(8'h40, 32'h0, "R1 dctl");
    for (int i = 0; i < 6; i++) rd(waddr[i], 32'h0, "R1 word");

    // R2 config register
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0079, "R2 cfg masked");
    chk({27'b0, cfg_en, cfg_type}, 32'h1F, "R2 cfg pins");
    wr(8'h00, 32'h0000_0028);
    rd(8'h00, 32'h0000_0028, "R2 cfg type5");
    chk({27'b0, cfg_en, cfg_type}, 32'h05, "R2 cfg pins type5");

    // R3 mode register
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0000_0035, "R3 mode mask");
    wr(8'h10, 32'h0000_0010);
    rd(8'h10, 32'h0000_0010, "R3 mode m2m");

    // R4 random word traffic
    for (int i = 0; i < 6; i++) words[i] = '0;
    for (int n = 0; n < 60; n++) begin
      int j = int'($urandom_range(0, 5));
      logic [31:0] d = $urandom();
      wr(waddr[j], d);
      words[j] = d;
      j = int'($urandom_range(0, 5));
      rd(waddr[j], words[j], "R4 word readback");
    end

    // R9 spare breakdown for every type index
    for (int k = 0; k < 16; k++) begin
      wr(8'h00, 32'(k) << 3);
      wr(8'h28, 32'hDEAD_BEEF);
      rd(8'h28, spare_exp(4'(k)), "R9 spare fields");
    end

    // R10 version
    wr(8'hD0, 32'h1234_5678);
    rd(8'hD0, 32'h0003_0000, "R10 version");

    // R11 unmapped addresses
    for (int n = 0; n < 20; n++) begin
      logic [7:0] a = {$urandom_range(0, 63), 2'b00};
      if (a inside {8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h24,
                    8'h28, 8'h30, 8'h40, 8'h44, 8'h48, 8'hD0})
        a = 8'h3C;
      wr(a, 32'hFFFF_FFFF);
      rd(a, 32'h0, "R11 unmapped read");
    end
    for (int i = 0; i < 6; i++) rd(waddr[i], words[i], "R11 words untouched");
    rd(8'h10, 32'h0000_0010, "R11 mode untouched");

    // R8 DMA control and start strobe
    wr(8'h40, 32'hE000_0002);
    #1;
    chk({30'b0, dma_start, dma_read}, 32'h3, "R8 start pulse high");
    @(negedge clk); #1;
    chk({31'b0, dma_start}, 32'h0, "R8 start pulse one cycle");
    rd(8'h40, 32'h6000_0002, "R8 dctl readback");
    wr(8'h40, 32'h0000_0000);
    #1;
    chk({30'b0, dma_start, dma_read}, 32'h0, "R8 no start, write dir");

    // R5/R6/R7 directed: gated latch, clear, collision
    wr(8'h08, 32'h0000_0005);
    wr(8'h0C, 32'h0000_0001);
    pulse(6'h3F);
    rd(8'h04, 32'h0000_0005, "R5 gated latch");
    chk({31'b0, irq}, 32'h1, "R7 irq from bit0");
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, 32'h0000_0004, "R6 w1c");
    chk({31'b0, irq}, 32'h0, "R7 irq masked bit2");
    @(negedge clk);
    reg_addr = 8'h04; reg_wdata = 32'h5; reg_we = 1'b1; evt_in = 6'h01;
    @(negedge clk);
    reg_we = 1'b0; evt_in = '0;
    rd(8'h04, 32'h0000_0001, "R6 event beats clear");
    wr(8'h04, 32'h0000_003F);

    // R5/R6/R7 random
    m_sts = '0;
    for (int n = 0; n < 80; n++) begin
      logic [5:0] e = 6'($urandom());
      logic [5:0] c = 6'($urandom());
      m_en  = 6'($urandom());
      m_sig = 6'($urandom());
      wr(8'h08, 32'(m_en));
      wr(8'h0C, 32'(m_sig));
      pulse(e);
      m_sts = m_sts | (e & m_en);
      rd(8'h04, 32'(m_sts), "R5 random latch");
      chk({31'b0, irq}, {31'b0, |(m_sts & m_sig)}, "R7 random irq");
      wr(8'h04, 32'(c));
      m_sts = m_sts & ~c;
      rd(8'h04, 32'(m_sts), "R6 random clear");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule